// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a small processor core stops its clock to save power and when it starts it again. The core sets a sleep-enable control bit and a two-bit mode select, then executes a sleep instruction, which arrives here as a one-cycle pulse. If the enable bit is set when that pulse is sampled, the controller gates the CPU clock. It also records the selected mode and drops the peripheral clock enables that the mode does not need.

While asleep, any asserted bit of the enabled-interrupt request vector wakes the device. The controller then holds the CPU in a fixed halt of `HALT_CYCLES` cycles, four by default, with all peripheral clocks running. After the halt it releases the core with a one-cycle pulse. That pulse tells the core to enter the interrupt handler and afterwards continue at the instruction after the sleep instruction. No register or memory state is touched.

The reset input is active low and asynchronous. Asserting it at any time, including during sleep or during the wake halt, returns the controller to the running state. The resume path is abandoned and a reset-vector indication is raised instead.

Top module: `sleep_power_ctrl`

## Requirements
- R1: While `rstN` is low: `cpuClkEn`=1, `perClkEn`=7'h7F, `wakeHalt`=0, `intEntry`=0 and `resetVec`=1. `resetVec` reads 0 from the first rising clock edge after `rstN` returns high.
- R2: When `sleepInstr` and `sleepEn` are both 1 at a rising edge in the running state, `cpuClkEn` is 0 from that edge on.
- R3: A `sleepInstr` pulse sampled while `sleepEn`=0 has no effect: `cpuClkEn` stays 1, and a following interrupt request raises no halt.
- R4: `modeSel` is {bit1, bit0}. Values 2'b00 and 2'b01 select Idle. In Idle all seven `perClkEn` bits stay 1. The bit order is 0 SPI, 1 UART, 2 analog comparator, 3 timer/counter, 4 watchdog, 5 interrupt logic, 6 asynchronous timer.
- R5: `modeSel`=2'b10 selects Power-down. While asleep in Power-down, `perClkEn`=7'h20: only the interrupt logic is enabled.
- R6: `modeSel`=2'b11 selects Power-save. While asleep in Power-save, `perClkEn`=7'h60: the interrupt logic and the asynchronous timer are enabled.
- R7: The mode is captured at sleep entry. Changes on `modeSel` while asleep do not change `perClkEn`.
- R8: Any set bit of `irqReq` sampled while asleep makes `wakeHalt` 1 from the next edge for exactly `HALT_CYCLES` cycles. During those cycles `cpuClkEn`=0 and `perClkEn`=7'h7F.
- R9: On the first cycle after the halt, `cpuClkEn`=1 and `intEntry`=1 for exactly one cycle.
- R10: Asserting `rstN` during sleep or during the halt immediately gives the R1 output state. No `intEntry` pulse follows after reset is released.
- R11: `irqReq` while running, without a sleep entry, raises no `wakeHalt` and leaves `cpuClkEn` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; also the reset wake source |
| sleepEn | input | 1 | Sleep-enable control bit |
| modeSel | input | 2 | Mode select: bit 1 main select, bit 0 extended select |
| sleepInstr | input | 1 | One-cycle pulse marking an executed sleep instruction |
| irqReq | input | NUM_IRQ | Enabled interrupt requests, any bit wakes |
| cpuClkEn | output | 1 | CPU clock-gate enable |
| perClkEn | output | 7 | Peripheral clock enables, bit order given in R4 |
| wakeHalt | output | 1 | CPU held during the post-wake stall |
| intEntry | output | 1 | One-cycle pulse: enter handler, then resume after the sleep instruction |
| resetVec | output | 1 | Execution must start from the reset vector |

## Verification
The bench walks entries in each mode, including the 2'b01 select that must fall back to Idle. A wrong decode shows up as a bad enable mask. It also issues a sleep instruction with the enable bit clear, which a careless design would treat as a sleep. The halt length is counted cycle by cycle, so an off-by-one counter gives a three- or five-cycle stall, or a misplaced `intEntry`. The bench changes the mode select during sleep, which catches a design that decodes the live pins instead of the captured mode. It also applies reset both in sleep and in the halt; a design that let the halt finish would emit a stray handler-entry pulse after reset.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_HALT  = 2'd2
  } slpStateT;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PDOWN = 2'd1,
    MODE_PSAVE = 2'd2
  } slpModeT;

  localparam int NUM_PER      = 7;
  localparam int PER_SPI      = 0;
  localparam int PER_UART     = 1;
  localparam int PER_ACMP     = 2;
  localparam int PER_TIMER    = 3;
  localparam int PER_WDOG     = 4;
  localparam int PER_INTLOGIC = 5;
  localparam int PER_ASYNCTMR = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic captureMode;
    logic loadCnt;
    logic decCnt;
    logic finishWake;
    logic sleepActive;
    logic haltActive;
  } slpCtrlT;

  // select bits {main, extended}; the undefined 01 folds onto Idle
  function automatic slpModeT decodeSel(input logic [1:0] sel);
    case (sel)
      2'b10:   return MODE_PDOWN;
      2'b11:   return MODE_PSAVE;
      default: return MODE_IDLE;
    endcase
  endfunction

  // peripherals kept clocked while asleep in a given mode
  function automatic logic [NUM_PER-1:0] keepMask(input slpModeT m);
    logic [NUM_PER-1:0] k;
    k = '0;
    case (m)
      MODE_PDOWN: k[PER_INTLOGIC] = 1'b1;
      MODE_PSAVE: begin
        k[PER_INTLOGIC] = 1'b1;
        k[PER_ASYNCTMR] = 1'b1;
      end
      default:    k = '1;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepEn,
  input  logic               sleepInstr,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               cntDone,
  output slpCtrlT            strb
);

  slpStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState        = state;
    strb             = '0;
    strb.sleepActive = (state == ST_SLEEP);
    strb.haltActive  = (state == ST_HALT);
    case (state)
      ST_RUN: begin
        if (sleepInstr && sleepEn) begin
          nextState        = ST_SLEEP;
          strb.captureMode = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (|irqReq) begin
          nextState    = ST_HALT;
          strb.loadCnt = 1'b1;
        end
      end
      ST_HALT: begin
        if (cntDone) begin
          nextState       = ST_RUN;
          strb.finishWake = 1'b1;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  assert_no_entry_when_disabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepInstr && !sleepEn) |=> (state == ST_RUN));

  assert_entry_on_enabled_instr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && sleepInstr && sleepEn) |=> (state == ST_SLEEP));

  assert_irq_wakes_to_halt_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && (|irqReq)) |=> (state == ST_HALT));

  assert_run_ignores_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !(sleepInstr && sleepEn)) |=> (state == ST_RUN));

endmodule

// File: rtl/slp_datapath.sv
module slp_datapath
  import slp_pkg::*;
#(
  parameter int HALT_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  slpCtrlT            strb,
  output logic               cntDone,
  output logic               cpuClkEn,
  output logic [NUM_PER-1:0] perClkEn,
  output logic               wakeHalt,
  output logic               intEntry,
  output logic               resetVec
);

  localparam int CNT_W = $clog2(HALT_CYCLES + 1);
  localparam int CHK_W = CNT_W + 2;

  slpModeT            modeReg;
  logic [CNT_W-1:0]   haltCnt;
  logic [NUM_PER-1:0] keep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 modeReg <= MODE_IDLE;
    else if (strb.captureMode) modeReg <= decodeSel(modeSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             haltCnt <= '0;
    else if (strb.loadCnt) haltCnt <= CNT_W'(HALT_CYCLES - 1);
    else if (strb.decCnt)  haltCnt <= haltCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEntry <= 1'b0;
      resetVec <= 1'b1;
    end else begin
      intEntry <= strb.finishWake;
      resetVec <= 1'b0;
    end
  end

  assign cntDone  = (haltCnt == '0);
  assign cpuClkEn = !strb.sleepActive && !strb.haltActive;
  assign wakeHalt = strb.haltActive;
  assign keep     = keepMask(modeReg);

  for (genvar i = 0; i < NUM_PER; i++) begin : g_perEn
    assign perClkEn[i] = !strb.sleepActive || keep[i];
  end

  // halt-length observer for the checks below
  logic [CHK_W-1:0] chkLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                chkLen <= '0;
    else if (strb.haltActive) chkLen <= chkLen + 1'b1;
    else                      chkLen <= '0;
  end

  assert_halt_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    intEntry |-> (chkLen == CHK_W'(HALT_CYCLES)));

  assert_entry_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    intEntry |=> !intEntry);

  assert_mode_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sleepActive && $past(strb.sleepActive)) |-> $stable(modeReg));

  assert_intlogic_alive_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.sleepActive |-> perClkEn[PER_INTLOGIC]);

endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int HALT_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepEn,
  input  logic [1:0]         modeSel,
  input  logic               sleepInstr,
  input  logic [NUM_IRQ-1:0] irqReq,
  output logic               cpuClkEn,
  output logic [6:0]         perClkEn,
  output logic               wakeHalt,
  output logic               intEntry,
  output logic               resetVec
);

  slpCtrlT strb;
  logic    cntDone;

  slp_ctrl #(.NUM_IRQ(NUM_IRQ)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sleepEn    (sleepEn),
    .sleepInstr (sleepInstr),
    .irqReq     (irqReq),
    .cntDone    (cntDone),
    .strb       (strb)
  );

  slp_datapath #(.HALT_CYCLES(HALT_CYCLES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .strb     (strb),
    .cntDone  (cntDone),
    .cpuClkEn (cpuClkEn),
    .perClkEn (perClkEn),
    .wakeHalt (wakeHalt),
    .intEntry (intEntry),
    .resetVec (resetVec)
  );

  assert_cpu_off_when_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeHalt |-> (!cpuClkEn && perClkEn == 7'h7F));

endmodule

// File: tb/sleep_power_ctrl_test.sv
module sleep_power_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALT       = 4;
  localparam int NVEC       = 6;

  // {sleepEn, modeSel[1:0], irqReq[3:0], expected sleep mask[6:0]}
  localparam logic [13:0] VECS [NVEC] = '{
    {1'b1, 2'b00, 4'b0001, 7'h7F},
    {1'b1, 2'b01, 4'b0010, 7'h7F},
    {1'b1, 2'b10, 4'b0100, 7'h20},
    {1'b1, 2'b11, 4'b1000, 7'h60},
    {1'b0, 2'b10, 4'b0001, 7'h7F},
    {1'b1, 2'b10, 4'b1111, 7'h20}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepEn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       sleepInstr = 1'b0;
  logic [3:0] irqReq = 4'b0;
  logic       cpuClkEn, wakeHalt, intEntry, resetVec;
  logic [6:0] perClkEn;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_power_ctrl uut (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .modeSel(modeSel),
    .sleepInstr(sleepInstr), .irqReq(irqReq), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .wakeHalt(wakeHalt), .intEntry(intEntry),
    .resetVec(resetVec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic resetCheck(input string req);
    chk(req, {31'b0, cpuClkEn}, 32'd1);
    chk(req, {25'b0, perClkEn}, 32'h7F);
    chk(req, {31'b0, wakeHalt}, 32'd0);
    chk(req, {31'b0, intEntry}, 32'd0);
    chk(req, {31'b0, resetVec}, 32'd1);
  endtask

  task automatic enterSleep(input logic en, input logic [1:0] m);
    sleepEn    = en;
    modeSel    = m;
    sleepInstr = 1'b1;
    @(negedge clk);
    sleepInstr = 1'b0;
  endtask

  // wake from sleep and check halt length and handler entry
  task automatic wakeAndCheck(input logic [3:0] irq);
    irqReq = irq;
    @(negedge clk);
    irqReq = 4'b0;
    for (int c = 0; c < HALT; c++) begin
      chk("R8 halt", {31'b0, wakeHalt}, 32'd1);
      chk("R8 cpu off", {31'b0, cpuClkEn}, 32'd0);
      chk("R8 per on", {25'b0, perClkEn}, 32'h7F);
      @(negedge clk);
    end
    chk("R8 halt over", {31'b0, wakeHalt}, 32'd0);
    chk("R9 entry", {31'b0, intEntry}, 32'd1);
    chk("R9 cpu on", {31'b0, cpuClkEn}, 32'd1);
    @(negedge clk);
    chk("R9 single", {31'b0, intEntry}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [13:0] v;
    repeat (2) @(negedge clk);
    resetCheck("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 resetVec clear", {31'b0, resetVec}, 32'd0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      enterSleep(v[13], v[12:11]);
      if (v[13]) begin
        chk("R2 asleep", {31'b0, cpuClkEn}, 32'd0);
        chk("R4 R5 R6 mask", {25'b0, perClkEn}, {25'b0, v[6:0]});
        repeat (2) @(negedge clk);
        chk("R2 still asleep", {31'b0, cpuClkEn}, 32'd0);
        wakeAndCheck(v[10:7]);
      end else begin
        chk("R3 ignored", {31'b0, cpuClkEn}, 32'd1);
        irqReq = v[10:7];
        @(negedge clk);
        irqReq = 4'b0;
        chk("R3 no halt", {31'b0, wakeHalt}, 32'd0);
        chk("R3 per on", {25'b0, perClkEn}, 32'h7F);
      end
      @(negedge clk);
    end

    // R11: interrupt while running
    irqReq = 4'b1111;
    repeat (3) @(negedge clk);
    irqReq = 4'b0;
    chk("R11 no halt", {31'b0, wakeHalt}, 32'd0);
    chk("R11 cpu on", {31'b0, cpuClkEn}, 32'd1);

    // R7: mode select changes during sleep
    enterSleep(1'b1, 2'b10);
    modeSel = 2'b00;
    repeat (2) @(negedge clk);
    chk("R7 held pdown", {25'b0, perClkEn}, 32'h20);
    modeSel = 2'b11;
    @(negedge clk);
    chk("R7 held pdown 2", {25'b0, perClkEn}, 32'h20);
    wakeAndCheck(4'b0010);

    // R10: reset during sleep
    enterSleep(1'b1, 2'b11);
    chk("R6 psave", {25'b0, perClkEn}, 32'h60);
    #1 rstN = 1'b0;
    #1 resetCheck("R10 reset in sleep");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 resetVec clear", {31'b0, resetVec}, 32'd0);
    chk("R10 running", {31'b0, cpuClkEn}, 32'd1);

    // R10: reset during halt
    enterSleep(1'b1, 2'b10);
    irqReq = 4'b0001;
    @(negedge clk);
    irqReq = 4'b0;
    @(negedge clk);
    chk("R10 in halt", {31'b0, wakeHalt}, 32'd1);
    #1 rstN = 1'b0;
    #1 resetCheck("R10 reset in halt");
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < HALT + 2; c++) begin
      @(negedge clk);
      chk("R10 no entry", {31'b0, intEntry}, 32'd0);
      chk("R10 no halt", {31'b0, wakeHalt}, 32'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule